// File: doc/BRIEF.md
# Flow-Gated UART Transmitter

This block is the transmit side of an asynchronous serial port. A parallel byte is written into a one-character holding register. From there it moves into a shift register, which sends it on a single serial line as a framed character. Every step is timed in periods of a baud enable that pulses sixteen times per bit. The move from the holding register to the shift register happens at fixed counts of those pulses. With the shifter idle, the move comes a few pulses after the write. With the shifter busy, the move happens inside the final stop bit so that characters follow each other with no gap.

An active-low clear-to-send input holds back a waiting character. While it is high, nothing leaves the holding register. When it falls, the character starts with the same latency as a fresh write. The flag that shows an empty holding register is driven out directly and also appears in a status byte. An interrupt line follows that flag, so software knows when to write the next byte.

Top module: `uart_tx_gated`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `hold_empty` is 1, `irq` is 1 and `status` is 8'h40.
- R2: A character is sent as a start bit (0), then the 8 data bits least significant bit first, then a stop bit (1). Each bit lasts 16 `baud_tick` pulses. The line rests at 1 between characters.
- R3: If the shifter is idle and `cts_n` is 0, `hold_empty` rises on the 4th `baud_tick` after the cycle that accepts the write, and `txd` falls on the 5th. A tick in the same cycle as the write is not counted.
- R4: A write accepted in a cycle before the 12th tick of the current character's stop bit is sent back to back. `hold_empty` rises on the 15th tick of that stop bit, and the next start bit begins on the 16th.
- R5: A write accepted in the cycle of the 12th stop-bit tick or later is not moved during that stop bit. The line goes idle when the stop bit ends, and the R3 latency is then counted from the end of the stop bit.
- R6: While `cts_n` is 1, a waiting character stays in the holding register: `hold_empty` stays 0 and `txd` stays 1.
- R7: When `cts_n` goes to 0 with a character waiting and the shifter idle, `hold_empty` rises on the 4th tick after that and `txd` falls on the 5th.
- R8: `cts_n` is sampled for the back-to-back move at the 12th tick of the stop bit. If it goes high after that point, the move does not stop.
- R9: `status` bit 6 equals `hold_empty` in every cycle, and all other `status` bits are 0.
- R10: `irq` is 1 whenever `hold_empty` is 1. It drops in the cycle after any write.
- R11: A write while the holding register is full replaces the waiting byte. Only the last byte is sent, and no flag shows that a byte was overwritten.
- R12: If a write lands in the same cycle as a move into the shifter, the older byte is sent first. The new byte stays in the holding register, and `hold_empty` and `irq` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | input | 1 | One-cycle enable at sixteen times the bit rate |
| wr_en | input | 1 | Write strobe; the byte is taken in this cycle |
| wr_data | input | 8 | Byte to transmit |
| cts_n | input | 1 | Clear-to-send, active low |
| txd | output | 1 | Serial data line |
| hold_empty | output | 1 | Holding register is empty |
| irq | output | 1 | Interrupt request, high while the holding register is empty |
| status | output | 8 | Status byte; bit 6 mirrors `hold_empty` |

## Verification
A CPU write and a move from the holding register into the shifter can fall in the same cycle. The bench lines a write up with the 15th stop-bit tick, the tick that triggers a back-to-back move, by counting clock cycles from the previous tick. It then expects `hold_empty` and `irq` to stay low. The scoreboard must see the older byte as the next frame and the newer byte as the one after it. The two timing cutoffs are tested at both edges: a write one tick before the 12th stop-bit tick goes back to back, while a write right after that tick waits for the idle latency. A clear-to-send release after that tick does not block the move.

// File: rtl/uart_txg_pkg.sv
package uart_txg_pkg;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_ARM  = 2'd1,
    SH_SEND = 2'd2
  } sh_state_e;

  localparam int STAT_W         = 8;
  localparam int STAT_EMPTY_BIT = 6;

endpackage

// File: rtl/txg_hold_buf.sv
module txg_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic [DATA_W-1:0] hold_data,
  output logic              hold_full,
  output logic              hold_empty,
  output logic              irq
);

  logic full_d;

  // a write always wins: with a simultaneous load the register refills
  always_comb begin
    if (wr_en)     full_d = 1'b1;
    else if (load) full_d = 1'b0;
    else           full_d = hold_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data  <= '0;
      hold_full  <= 1'b0;
      hold_empty <= 1'b1;
      irq        <= 1'b1;
    end else begin
      if (wr_en) hold_data <= wr_data;
      hold_full  <= full_d;
      hold_empty <= ~full_d;
      if (wr_en)     irq <= 1'b0;
      else if (load) irq <= 1'b1;
    end
  end

  p_write_clears_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (!hold_empty && !irq));

  p_irq_tracks_empty_r10: assert property (@(posedge clk) disable iff (rst)
    irq == hold_empty);

  p_load_needs_full_r12: assert property (@(posedge clk) disable iff (rst)
    load |-> hold_full);

endmodule

// File: rtl/txg_launch.sv
module txg_launch #(
  parameter int OVERSAMPLE  = 16,
  parameter int LOAD_TICKS  = 4,
  parameter int CUTOFF_TICK = 12,
  parameter int XFER_TICK   = 15,
  localparam int TCW = $clog2(OVERSAMPLE),
  localparam int LCW = $clog2(LOAD_TICKS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           hold_full,
  input  logic           cts_n,
  input  logic           sh_idle,
  input  logic           in_stop,
  input  logic [TCW-1:0] tick_pos,
  output logic           load
);

  localparam logic [LCW-1:0] LD_LAST  = LCW'(LOAD_TICKS - 1);
  localparam logic [TCW-1:0] CUT_POS  = TCW'(CUTOFF_TICK - 1);
  localparam logic [TCW-1:0] XFER_POS = TCW'(XFER_TICK - 1);

  logic [LCW-1:0] idle_cnt;
  logic           eligible;
  logic           idle_go;
  logic           load_idle;
  logic           load_b2b;

  assign idle_go   = hold_full && !cts_n && sh_idle;
  assign load_idle = idle_go && tick && (idle_cnt == LD_LAST);
  assign load_b2b  = in_stop && tick && (tick_pos == XFER_POS) && eligible && hold_full;
  assign load      = load_idle || load_b2b;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_cnt <= '0;
      eligible <= 1'b0;
    end else begin
      // idle latency: count ticks while a character waits and sending is allowed
      if (!idle_go)
        idle_cnt <= '0;
      else if (tick)
        idle_cnt <= (idle_cnt == LD_LAST) ? '0 : idle_cnt + 1'b1;
      // back-to-back decision frozen at the cutoff tick of the stop bit
      if (!in_stop)
        eligible <= 1'b0;
      else if (tick && (tick_pos == CUT_POS))
        eligible <= hold_full && !cts_n;
    end
  end

  p_b2b_after_cutoff_r8: assert property (@(posedge clk) disable iff (rst)
    (in_stop && tick && (tick_pos == CUT_POS) && (!hold_full || cts_n)) |=> !eligible);

endmodule

// File: rtl/txg_shifter.sv
module txg_shifter
  import uart_txg_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16,
  localparam int TCW = $clog2(OVERSAMPLE),
  localparam int BIW = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              txd,
  output logic              sh_idle,
  output logic              in_stop,
  output logic [TCW-1:0]    tick_pos
);

  localparam logic [TCW-1:0] TC_LAST  = TCW'(OVERSAMPLE - 1);
  localparam logic [BIW-1:0] STOP_IDX = BIW'(DATA_W + 1);
  localparam logic [BIW-1:0] DATA_END = BIW'(DATA_W);

  sh_state_e         state_q;
  logic [TCW-1:0]    tick_cnt;
  logic [BIW-1:0]    bit_idx;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] shr_q;
  logic              pend_q;

  assign sh_idle  = (state_q == SH_IDLE);
  assign in_stop  = (state_q == SH_SEND) && (bit_idx == STOP_IDX);
  assign tick_pos = tick_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SH_IDLE;
      tick_cnt <= '0;
      bit_idx  <= '0;
      data_q   <= '0;
      shr_q    <= '0;
      pend_q   <= 1'b0;
      txd      <= 1'b1;
    end else begin
      case (state_q)
        SH_ARM: begin
          if (tick) begin
            state_q  <= SH_SEND;
            tick_cnt <= '0;
            bit_idx  <= '0;
            shr_q    <= data_q;
            pend_q   <= 1'b0;
            txd      <= 1'b0;
          end
        end
        SH_SEND: begin
          if (tick) begin
            if (tick_cnt == TC_LAST) begin
              tick_cnt <= '0;
              if (bit_idx == STOP_IDX) begin
                if (pend_q) begin
                  bit_idx <= '0;
                  shr_q   <= data_q;
                  pend_q  <= 1'b0;
                  txd     <= 1'b0;
                end else begin
                  state_q <= SH_IDLE;
                  txd     <= 1'b1;
                end
              end else begin
                bit_idx <= bit_idx + 1'b1;
                if (bit_idx < DATA_END) begin
                  txd   <= shr_q[0];
                  shr_q <= shr_q >> 1;
                end else begin
                  txd <= 1'b1;
                end
              end
            end else begin
              tick_cnt <= tick_cnt + 1'b1;
            end
          end
        end
        default: begin
          txd <= 1'b1;
        end
      endcase
      // a move from the holding register parks the byte until its start bit
      if (load) begin
        data_q <= load_data;
        pend_q <= 1'b1;
        if (state_q == SH_IDLE) state_q <= SH_ARM;
      end
    end
  end

  p_idle_line_high_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == SH_IDLE) |-> txd);

  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    ((state_q == SH_SEND) && (bit_idx == '0)) |-> !txd);

  p_stop_high_r2: assert property (@(posedge clk) disable iff (rst)
    in_stop |-> txd);

  p_load_only_in_stop_r4: assert property (@(posedge clk) disable iff (rst)
    load |-> ((state_q == SH_IDLE) || in_stop));

endmodule

// File: rtl/uart_tx_gated.sv
module uart_tx_gated
  import uart_txg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int LOAD_TICKS  = 4,
  parameter int CUTOFF_TICK = 12,
  parameter int XFER_TICK   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cts_n,
  output logic              txd,
  output logic              hold_empty,
  output logic              irq,
  output logic [STAT_W-1:0] status
);

  localparam int TCW = $clog2(OVERSAMPLE);

  logic [DATA_W-1:0] hold_data;
  logic              hold_full;
  logic              load;
  logic              sh_idle;
  logic              in_stop;
  logic [TCW-1:0]    tick_pos;

  txg_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .load       (load),
    .hold_data  (hold_data),
    .hold_full  (hold_full),
    .hold_empty (hold_empty),
    .irq        (irq)
  );

  txg_launch #(
    .OVERSAMPLE  (OVERSAMPLE),
    .LOAD_TICKS  (LOAD_TICKS),
    .CUTOFF_TICK (CUTOFF_TICK),
    .XFER_TICK   (XFER_TICK)
  ) u_launch (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .hold_full (hold_full),
    .cts_n     (cts_n),
    .sh_idle   (sh_idle),
    .in_stop   (in_stop),
    .tick_pos  (tick_pos),
    .load      (load)
  );

  txg_shifter #(
    .DATA_W     (DATA_W),
    .OVERSAMPLE (OVERSAMPLE)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .load      (load),
    .load_data (hold_data),
    .txd       (txd),
    .sh_idle   (sh_idle),
    .in_stop   (in_stop),
    .tick_pos  (tick_pos)
  );

  always_comb begin
    status                 = '0;
    status[STAT_EMPTY_BIT] = hold_empty;
  end

  p_gated_line_r6: assert property (@(posedge clk) disable iff (rst)
    (sh_idle && cts_n && hold_full) |=> (txd && !hold_empty));

endmodule

// File: tb/test_uart_tx_gated.sv
module test_uart_tx_gated;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cts_n = 1'b0;
  logic       txd;
  logic       hold_empty;
  logic       irq;
  logic [7:0] status;

  int checks = 0;
  int fails = 0;
  int tick_no = 0;
  int tdiv = 0;
  int frames_rx = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  uart_tx_gated i_uart_tx_gated (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .cts_n      (cts_n),
    .txd        (txd),
    .hold_empty (hold_empty),
    .irq        (irq),
    .status     (status)
  );

  // baud enable: one cycle in three
  always @(negedge clk) begin
    if (rst) begin
      tdiv      <= 0;
      baud_tick <= 1'b0;
    end else begin
      tdiv      <= (tdiv == 2) ? 0 : tdiv + 1;
      baud_tick <= (tdiv == 2);
    end
  end

  always @(posedge clk) if (!rst && baud_tick) tick_no <= tick_no + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_tick(input int n);
    while (tick_no < n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // driver: write at the current negedge, push the expected byte
  task automatic do_write(input logic [7:0] d, input bit replace);
    wr_en   = 1'b1;
    wr_data = d;
    if (replace) void'(exp_q.pop_back());
    exp_q.push_back(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: decode frames mid-bit and compare with the scoreboard (R2)
  initial begin
    int ts;
    logic [7:0] rx;
    logic s0, sp;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        ts = tick_no;
        wait_tick(ts + 8);
        s0 = txd;
        for (int b = 0; b < 8; b++) begin
          wait_tick(ts + 24 + 16 * b);
          rx[b] = txd;
        end
        wait_tick(ts + 152);
        sp = txd;
        frames_rx++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected frame", int'(rx), 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx == e && s0 == 1'b0 && sp == 1'b1, "R2", "frame byte", int'(rx), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int tw, t0, t1, t2, t3, t4, t5, t6, t7, tc;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1 && hold_empty && irq, "R1", "reset outputs",
        int'({txd, hold_empty, irq}), 3'b111);
    chk(status == 8'h40, "R1", "reset status", int'(status), 8'h40);

    // idle launch
    do_write(8'hA5, 1'b0);
    tw = tick_no;
    chk(!hold_empty && !irq, "R10", "write clears irq", int'({hold_empty, irq}), 0);
    chk(status == 8'h00, "R9", "status after write", int'(status), 0);
    wait_tick(tw + 3); chk(!hold_empty, "R3", "empty before 4th tick", int'(hold_empty), 0);
    wait_tick(tw + 4); chk(hold_empty && txd, "R3", "empty on 4th tick", int'({hold_empty, txd}), 3);
    chk(status == 8'h40 && irq, "R9", "status and irq on empty", int'(status), 8'h40);
    wait_tick(tw + 5); chk(!txd, "R3", "start on 5th tick", int'(txd), 0);
    t0 = tw + 5;

    // back-to-back, write one tick before the cutoff
    wait_tick(t0 + 155);
    do_write(8'h3C, 1'b0);
    wait_tick(t0 + 158); chk(!hold_empty, "R4", "empty before 15th", int'(hold_empty), 0);
    wait_tick(t0 + 159); chk(hold_empty && txd, "R4", "empty on 15th", int'({hold_empty, txd}), 3);
    wait_tick(t0 + 160); chk(!txd, "R4", "start on 16th", int'(txd), 0);
    t1 = t0 + 160;

    // late write, just after the cutoff tick
    wait_tick(t1 + 156);
    do_write(8'h77, 1'b0);
    wait_tick(t1 + 159); chk(!hold_empty, "R5", "no move on 15th", int'(hold_empty), 0);
    wait_tick(t1 + 160); chk(txd, "R5", "line idle after stop", int'(txd), 1);
    wait_tick(t1 + 163); chk(!hold_empty, "R5", "empty before 4th idle tick", int'(hold_empty), 0);
    wait_tick(t1 + 164); chk(hold_empty, "R5", "empty on 4th idle tick", int'(hold_empty), 1);
    wait_tick(t1 + 165); chk(!txd, "R5", "start on 5th idle tick", int'(txd), 0);
    t2 = t1 + 165;

    // clear-to-send held inactive before the cutoff
    wait_tick(t2 + 20);
    cts_n = 1'b1;
    do_write(8'h11, 1'b0);
    wait_tick(t2 + 159); chk(!hold_empty, "R6", "gated at 15th", int'(hold_empty), 0);
    wait_tick(t2 + 160); chk(txd, "R6", "gated at 16th", int'(txd), 1);
    wait_tick(t2 + 230);
    chk(!hold_empty && txd, "R6", "still waiting", int'({hold_empty, txd}), 1);
    tc = tick_no;
    cts_n = 1'b0;
    wait_tick(tc + 3); chk(!hold_empty, "R7", "empty before 4th", int'(hold_empty), 0);
    wait_tick(tc + 4); chk(hold_empty, "R7", "empty on 4th", int'(hold_empty), 1);
    wait_tick(tc + 5); chk(!txd, "R7", "start on 5th", int'(txd), 0);
    t3 = tc + 5;

    // clear-to-send raised after the cutoff does not block
    wait_tick(t3 + 10);
    do_write(8'h22, 1'b0);
    wait_tick(t3 + 156);
    cts_n = 1'b1;
    wait_tick(t3 + 159); chk(hold_empty, "R8", "move despite late cts", int'(hold_empty), 1);
    wait_tick(t3 + 160); chk(!txd, "R8", "start despite late cts", int'(txd), 0);
    cts_n = 1'b0;
    t4 = t3 + 160;

    // overwrite while full: only 0x66 goes out
    wait_tick(t4 + 10);
    do_write(8'h55, 1'b0);
    do_write(8'h66, 1'b1);
    chk(!hold_empty && !irq && status == 8'h00, "R11", "no overwrite flag",
        int'({hold_empty, irq}), 0);
    wait_tick(t4 + 159); chk(hold_empty, "R11", "one move after overwrite", int'(hold_empty), 1);
    wait_tick(t4 + 160); chk(!txd, "R11", "start of overwritten char", int'(txd), 0);
    t5 = t4 + 160;

    // write in the same cycle as the back-to-back move
    wait_tick(t5 + 10);
    do_write(8'h81, 1'b0);
    wait_tick(t5 + 158);
    @(negedge clk);
    @(negedge clk);
    do_write(8'h92, 1'b0);
    chk(tick_no == t5 + 159, "R12", "write aligned with move tick", tick_no, t5 + 159);
    chk(!hold_empty && !irq, "R12", "new byte held", int'({hold_empty, irq}), 0);
    wait_tick(t5 + 160); chk(!txd, "R12", "older byte starts", int'(txd), 0);
    t6 = t5 + 160;
    wait_tick(t6 + 158); chk(!hold_empty, "R12", "held until next stop", int'(hold_empty), 0);
    wait_tick(t6 + 159); chk(hold_empty, "R12", "newer byte moves", int'(hold_empty), 1);
    wait_tick(t6 + 160); chk(!txd, "R12", "newer byte starts", int'(txd), 0);
    t7 = t6 + 160;

    wait_tick(t7 + 175);
    chk(txd && hold_empty && irq && status == 8'h40, "R10", "final idle",
        int'({txd, hold_empty, irq}), 3'b111);
    chk(exp_q.size() == 0, "R11", "scoreboard drained", exp_q.size(), 0);
    chk(frames_rx == 8, "R2", "frame count", frames_rx, 8);
    finish_run();
  end

endmodule